// File: doc/BRIEF.md
# Edge-Latched Interrupt Flag Controller

This block gathers up to six asynchronous event lines and turns them into one level-sensitive interrupt request. Every line has an enable bit. When a line rises while its enable bit is set, the block latches a flag for that line. The request output stays high for as long as any flag is set.

Software reaches the block through one byte-wide register location. A write to that location loads the six enable bits. A read from it returns the six latched flags. There is no separate acknowledge register. Software drops a flag by clearing its enable bit. The usual service sequence is: read the flags, write the enables with the serviced bits cleared, then write the enables again with those bits set. Turning a source back on does not raise its flag again, because a flag needs a fresh rising edge. The address decode and the origin of the event lines belong to the surrounding logic.

Top module: `irq_edge_latch`

## Requirements
- R1: After reset the six enable bits are 0, every flag is 0, the read data is 0x00 and `irq_o` is low.
- R2: A source line goes through a two-stage synchroniser and then an edge register. When `src_i[n]` goes high before clock edge k and enable bit n is set, flag n first reads 1 after edge k+2.
- R3: A rising edge that arrives while a source is disabled is discarded. The flag does not appear later when the source is enabled with the line still high.
- R4: A set flag stays set after its source line falls, and it stays set while the line remains high.
- R5: A write with bit n of `reg_wdata_i` at 0 clears flag n, effective from the clock edge that takes the write. Bit n of the write data is the enable for source n.
- R6: A write of 0x00 clears all flags and forces `irq_o` low after that edge.
- R7: A source that is enabled again with no new rising edge keeps its flag at 0. A later rising edge sets the flag again.
- R8: `irq_o` is high exactly when at least one flag is set. Bit n of `reg_rdata_o` is flag n, and bits 7:6 always read 0.
- R9: A falling edge on a source line never sets a flag.
- R10: When a detected edge and a write that disables the same source meet at one clock edge, the flag stays 0. Other enabled sources are not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 6 | Asynchronous event lines, one per source |
| reg_we_i | input | 1 | Write strobe for the enable register |
| reg_wdata_i | input | 8 | Write data; bit n enables source n, bits 7:6 unused |
| reg_rdata_o | output | 8 | Read data; bit n is flag n, bits 7:6 zero |
| irq_o | output | 1 | Interrupt request, high while any flag is set |

## Verification
Two things can land on the same clock edge: a synchronised rising edge about to set a flag, and a software write that disables that source. The bench raises source 2 and source 5 together. It then times a write that disables only source 2 so that the write is captured on the edge at which the detected edge would latch. The check passes only if flag 2 stays clear while flag 5 still latches, which shows that the disable wins for its own bit and leaves the other bits untouched.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
  parameter int unsigned NUM_SRC = 6;
  parameter int unsigned REG_W   = 8;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned N      = irq_edge_pkg::NUM_SRC,
  parameter int unsigned STAGES = irq_edge_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], src_i[g]};
        prev_q <= sync_q[LAST];
      end
    end

    assign rise_o[g] = sync_q[LAST] & ~prev_q;

    // R2: a detected edge lasts one cycle only
    a_r2_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = irq_edge_pkg::NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic         we_i,
  input  logic [N-1:0] en_wr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] en_q, en_d;
  logic [N-1:0] status_q, status_d;

  always_comb begin
    en_d     = en_q;
    status_d = status_q | (rise_i & en_q);
    if (we_i) begin
      en_d     = en_wr_i;
      status_d = status_d & en_wr_i;  // disable beats a same-cycle edge
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      status_q <= '0;
    end else begin
      en_q     <= en_d;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  // R5, R10: a disabled bit reads clear after the write edge
  a_r5_clear_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((status_q & ~$past(en_wr_i)) == '0));

  // R3: a flag can only appear on a source enabled before the edge
  a_r3_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int unsigned NSRC  = irq_edge_pkg::NUM_SRC,
  parameter int unsigned REG_W = irq_edge_pkg::REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  src_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  localparam int unsigned PAD_W = REG_W - NSRC;

  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] status;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-1:NSRC];

  irq_src_sync #(.N(NSRC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (rise)
  );

  irq_status_bank #(.N(NSRC)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .we_i     (reg_we_i),
    .en_wr_i  (reg_wdata_i[NSRC-1:0]),
    .status_o (status)
  );

  assign reg_rdata_o = {{PAD_W{1'b0}}, status};
  assign irq_o       = |status;

  // R7: a new flag always follows a detected edge
  a_r7_set_needs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status & ~$past(status) & ~$past(rise)) == '0));

  // R6: writing all-zero enables drops the request
  a_r6_zero_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[NSRC-1:0] == '0) |=> !irq_o);
endmodule

// File: tb/sim_irq_edge_latch.sv
module sim_irq_edge_latch;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] rd_q[$];
  logic       irq_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  irq_edge_latch u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_i       (src),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  // expectation is judged at the next falling edge
  task automatic push(logic [7:0] rd, string tag);
    rd_q.push_back(rd);
    irq_q.push_back(rd != 8'h00);  // R8: request equals OR of flags
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic [7:0] v);
    we = 1'b1;
    wdata = v;
    step();
    we = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_q.size() > 0) begin
        logic [7:0] e_rd;
        logic       e_irq;
        string      t;
        e_rd = rd_q.pop_front();
        e_irq = irq_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e_rd || irq !== e_irq) begin
          failures++;
          $display("FAIL %s rdata=%02h irq=%b expected rdata=%02h irq=%b",
                   t, rdata, irq, e_rd, e_irq);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // driver
  initial begin
    step(3);
    rst_n = 1'b1;
    push(8'h00, "R1 reset state");
    step();

    // R3: edge with no enables, then enable with line still high
    src[0] = 1'b1;
    step(4);
    push(8'h00, "R3 edge while disabled");
    step();
    wr(8'h01);
    step(3);
    push(8'h00, "R3 enable after edge");
    step();
    src[0] = 1'b0;
    wr(8'h3F);
    step(3);

    // R2: latency of the synchroniser and edge register
    src[1] = 1'b1;
    step();
    push(8'h00, "R2 not yet latched");
    step();
    push(8'h02, "R2 latched after third edge");
    step();

    // R4 and R9: sticky flag, falling edge does nothing
    step(2);
    push(8'h02, "R4 held while high");
    step();
    src[1] = 1'b0;
    step(4);
    push(8'h02, "R4 R9 held after fall");
    step();

    // R8: two flags, upper bits zero
    src[4] = 1'b1;
    step(3);
    push(8'h12, "R8 two flags");
    step();

    // R5: disable bit 1 only
    wr(8'h3D);
    push(8'h10, "R5 clear via disable");
    step();

    // R7: service sequence, line still high
    wr(8'h2F);
    push(8'h00, "R7 disable flag 4");
    step();
    wr(8'h3F);
    step(4);
    push(8'h00, "R7 re-enable no edge");
    step();
    src[4] = 1'b0;
    step(3);
    src[4] = 1'b1;
    step(3);
    push(8'h10, "R7 new edge sets again");
    step();

    // R6: clear everything
    wr(8'h00);
    push(8'h00, "R6 zero write");
    step();

    // R10: edge and disabling write on the same edge
    wr(8'h3F);
    step(2);
    src[2] = 1'b1;
    src[5] = 1'b1;
    step(2);
    we = 1'b1;
    wdata = 8'h3B;
    push(8'h20, "R10 disable wins for bit 2");
    step();
    we = 1'b0;
    step(3);
    push(8'h20, "R10 stays clear after");
    step(2);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule